// File: doc/BRIEF.md
# Battery-Domain Register Bank with Tamper Wipe and Shared Pin Output

This block holds forty-two 16-bit user words and one control word inside a battery-backed domain. The contents survive an ordinary system reset. They are lost only when the domain's own reset is asserted or when an armed external tamper event occurs. Software reaches the bank over a simple synchronous peripheral bus with 32-bit data. Both halfword and word accesses land on the low 16 bits of a register.

The block also owns a single shared pin. The pin serves either as the tamper input or as an output. As an output it carries one of three things: a one-cycle pulse made from an incoming alarm event, a one-cycle pulse made from an incoming seconds event, or the RTC clock divided by 64. The bank clock `clk` is the RTC clock. The counter that produces the alarm and seconds events lives elsewhere, so those events arrive as inputs.

While the pin is used as an output, tamper detection is suppressed. This keeps the block's own output from wiping the bank.

Top module: `bkp_domain_bank`

## Requirements
- R1: Data word k (k = 0..9) sits at byte offset 0x04 + 4k, and word k (k = 10..41) sits at 0x40 + 4(k-10). A write stores `bus_wdata[15:0]`. A read returns the stored value in `bus_rdata[15:0]`, and `bus_rdata[31:16]` always reads zero.
- R2: The control word sits at offset 0x2C and has these fields:
  - bits 6:0: calibration value
  - bit 7: clock-output enable
  - bit 8: pulse-output enable
  - bit 9: pulse source select (0 = alarm, 1 = seconds)
  - bits 15:10: always read zero.
- R3: Reads of unmapped offsets return zero, and writes to them change nothing. When `bus_addr[1]` = 1 the access targets the upper halfword: it reads zero and writes to it are ignored.
- R4: `bkp_rst_n` low clears all data words and the calibration, pulse-enable and select fields. It leaves the clock-output enable unchanged.
- R5: `vdd_rst_n` low clears only the clock-output enable. Data words and the other control fields keep their values.
- R6: With `tamper_en` = 1 and both output modes off, a rising edge on `tamper_in` passes through two synchronizer flops. All data words then read zero from the third rising clock edge after `tamper_in` is first sampled high. The control word is not changed.
- R7: A tamper rising edge has no effect while `tamper_en` = 0, or while the clock output or the pulse output is enabled.
- R8: With only the pulse output enabled, `pin_oe` = 1. Each rising edge of the selected source drives `pin_out` high for exactly one clock, in the cycle after the source is first sampled high.
- R9: With the clock output enabled, `pin_oe` = 1 and `pin_out` is a square wave of period 64 clocks, high for 32 and low for 32. This holds whatever the pulse-output settings are.
- R10: With both output modes off, `pin_oe` = 0 and `pin_out` = 0.
- R11: Holding `tamper_in` high produces a single wipe. Data written while it stays high is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RTC clock, also the bus clock |
| bkp_rst_n | input | 1 | Battery-domain reset, active low |
| vdd_rst_n | input | 1 | Main-supply power-off reset, active low |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; zero when no read is active |
| tamper_en | input | 1 | Arms tamper detection |
| tamper_in | input | 1 | Tamper level seen on the shared pin |
| alarm_evt | input | 1 | Alarm event from the RTC counter |
| second_evt | input | 1 | Seconds event from the RTC counter |
| pin_out | output | 1 | Value driven on the shared pin |
| pin_oe | output | 1 | Output enable for the shared pin |

## Verification
The hardest situation to reach is a tamper edge that arrives while an output mode is enabled and then has to leave no trace. Reaching it takes a control-word write, a tamper rise while that mode is active, and then a readback of the bank. The stimulus raises `tamper_in` under clock-output mode, holds it, and confirms afterwards that the data is intact. It then drops the output mode and raises `tamper_in` again, and times the wipe edge by edge. Random traffic over the whole 8-bit offset space, including upper-halfword offsets, is checked against a bench model of the address map.

// File: rtl/bkp_pkg.sv
package bkp_pkg;
  // Maps a byte offset to a data-word index, or -1 when no data word lives there.
  function automatic int word_index(input logic [7:0] a, input int lo_base, input int lo_n,
                                    input int hi_base, input int hi_n);
    int off;
    off = int'({a[7:2], 2'b00});
    if (off >= lo_base && off < lo_base + 4 * lo_n) return (off - lo_base) / 4;
    if (off >= hi_base && off < hi_base + 4 * hi_n) return lo_n + (off - hi_base) / 4;
    return -1;
  endfunction
endpackage

// File: rtl/bkp_word_store.sv
module bkp_word_store #(
  parameter int NUM = 42,
  parameter int DW  = 16,
  localparam int IW = $clog2(NUM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wipe,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rword
);
  logic [DW-1:0] mem [NUM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM; i++) mem[i] <= '0;
    end else if (wipe) begin
      for (int i = 0; i < NUM; i++) mem[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < NUM; i++)
        if (idx == IW'(i)) mem[i] <= wdata;
    end
  end

  always_comb begin
    rword = '0;
    for (int i = 0; i < NUM; i++)
      if (idx == IW'(i)) rword = mem[i];
  end
endmodule

// File: rtl/bkp_tamper_sync.sv
module bkp_tamper_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic arm,
  output logic wipe
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  // rising edge of the synchronized level, gated by the arm condition
  assign wipe = arm & s2_q & ~s3_q;
endmodule

// File: rtl/bkp_pin_mux.sv
module bkp_pin_mux #(
  parameter int DIV_LOG2 = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_out_en,
  input  logic pulse_en,
  input  logic pulse_sel,
  input  logic alarm_evt,
  input  logic second_evt,
  output logic pin_out,
  output logic pin_oe
);
  logic [DIV_LOG2-1:0] div_q;
  logic src, src_prev_q, out_q;

  assign src = pulse_sel ? second_evt : alarm_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q      <= '0;
      src_prev_q <= 1'b0;
      out_q      <= 1'b0;
    end else begin
      div_q      <= div_q + 1'b1;
      src_prev_q <= src;
      if (clk_out_en)    out_q <= div_q[DIV_LOG2-1];
      else if (pulse_en) out_q <= src & ~src_prev_q;
      else               out_q <= 1'b0;
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = clk_out_en | pulse_en;
endmodule

// File: rtl/bkp_domain_bank.sv
module bkp_domain_bank #(
  parameter int NUM_LOW   = 10,
  parameter int NUM_HIGH  = 32,
  parameter int LOW_BASE  = 'h04,
  parameter int HIGH_BASE = 'h40,
  parameter int CTRL_OFF  = 'h2C,
  parameter int CAL_W     = 7,
  parameter int DIV_LOG2  = 6,
  parameter int DW        = 16
) (
  input  logic        clk,
  input  logic        bkp_rst_n,
  input  logic        vdd_rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        tamper_en,
  input  logic        tamper_in,
  input  logic        alarm_evt,
  input  logic        second_evt,
  output logic        pin_out,
  output logic        pin_oe
);
  import bkp_pkg::*;

  localparam int NUM     = NUM_LOW + NUM_HIGH;
  localparam int IW      = $clog2(NUM);
  localparam int CEN_BIT = CAL_W;
  localparam int PEN_BIT = CAL_W + 1;
  localparam int SEL_BIT = CAL_W + 2;

  int            widx_i;
  logic [IW-1:0] widx;
  logic          data_hit, ctrl_hit, wr_go, rd_go;
  logic [DW-1:0] word_rd, ctrl_word;
  logic [CAL_W-1:0] cal_q;
  logic          sel_q, pen_q, cen_q;
  logic          wipe;

  always_comb widx_i = word_index(bus_addr, LOW_BASE, NUM_LOW, HIGH_BASE, NUM_HIGH);
  assign widx     = widx_i[IW-1:0];
  assign data_hit = !bus_addr[1] && (widx_i >= 0);
  assign ctrl_hit = !bus_addr[1] && ({bus_addr[7:2], 2'b00} == CTRL_OFF[7:0]);
  assign wr_go    = bus_sel & bus_wr;
  assign rd_go    = bus_sel & ~bus_wr;

  bkp_word_store #(.NUM(NUM), .DW(DW)) u_store (
    .clk(clk), .rst_n(bkp_rst_n), .wipe(wipe), .we(wr_go & data_hit),
    .idx(widx), .wdata(bus_wdata[DW-1:0]), .rword(word_rd)
  );

  // fields cleared by the battery-domain reset
  always_ff @(posedge clk or negedge bkp_rst_n) begin
    if (!bkp_rst_n) begin
      cal_q <= '0;
      sel_q <= 1'b0;
      pen_q <= 1'b0;
    end else if (wr_go && ctrl_hit) begin
      cal_q <= bus_wdata[CAL_W-1:0];
      sel_q <= bus_wdata[SEL_BIT];
      pen_q <= bus_wdata[PEN_BIT];
    end
  end

  // clock-output enable follows the main-supply reset instead
  always_ff @(posedge clk or negedge vdd_rst_n) begin
    if (!vdd_rst_n)              cen_q <= 1'b0;
    else if (wr_go && ctrl_hit)  cen_q <= bus_wdata[CEN_BIT];
  end

  assign ctrl_word = {{(DW-CAL_W-3){1'b0}}, sel_q, pen_q, cen_q, cal_q};

  always_comb begin
    bus_rdata = '0;
    if (rd_go && data_hit)      bus_rdata = {{(32-DW){1'b0}}, word_rd};
    else if (rd_go && ctrl_hit) bus_rdata = {{(32-DW){1'b0}}, ctrl_word};
  end

  bkp_tamper_sync u_tamper (
    .clk(clk), .rst_n(bkp_rst_n), .pin_in(tamper_in),
    .arm(tamper_en & ~cen_q & ~pen_q), .wipe(wipe)
  );

  bkp_pin_mux #(.DIV_LOG2(DIV_LOG2)) u_pin (
    .clk(clk), .rst_n(vdd_rst_n), .clk_out_en(cen_q), .pulse_en(pen_q),
    .pulse_sel(sel_q), .alarm_evt(alarm_evt), .second_evt(second_evt),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );
endmodule

// File: rtl/bkp_bank_checker.sv
module bkp_bank_checker #(
  parameter int CTRL_OFF = 'h2C
) (
  input logic        clk,
  input logic        bkp_rst_n,
  input logic        vdd_rst_n,
  input logic        wipe,
  input logic        clk_out_en,
  input logic        pulse_en,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_rdata,
  input logic        pin_out
);
  logic ctrl_addr;
  assign ctrl_addr = ({bus_addr[7:2], 2'b00} == CTRL_OFF[7:0]) && !bus_addr[1];

  assert_wipe_gated_R7: assert property (@(posedge clk) disable iff (!bkp_rst_n || !vdd_rst_n)
    wipe |-> !(clk_out_en || pulse_en));

  assert_wipe_clears_R6: assert property (@(posedge clk) disable iff (!bkp_rst_n || !vdd_rst_n)
    wipe |=> (ctrl_addr || bus_rdata == 32'd0));

  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!bkp_rst_n)
    bus_rdata[31:16] == 16'd0);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!bkp_rst_n)
    ctrl_addr |-> bus_rdata[15:10] == 6'd0);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!vdd_rst_n || !bkp_rst_n)
    (pin_out && !clk_out_en && !$past(clk_out_en)) |=> (!pin_out || clk_out_en));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!vdd_rst_n || !bkp_rst_n)
    (!clk_out_en && !pulse_en && !$past(clk_out_en) && !$past(pulse_en)) |-> !pin_out);
endmodule

bind bkp_domain_bank bkp_bank_checker #(.CTRL_OFF(CTRL_OFF)) u_chk (
  .clk(clk), .bkp_rst_n(bkp_rst_n), .vdd_rst_n(vdd_rst_n), .wipe(wipe),
  .clk_out_en(cen_q), .pulse_en(pen_q), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .pin_out(pin_out)
);

// File: tb/test_bkp_domain_bank.sv
`timescale 1ns/1ps
module test_bkp_domain_bank;
  logic        clk = 1'b0;
  logic        bkp_rst_n = 1'b0, vdd_rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        tamper_en = 1'b0, tamper_in = 1'b0;
  logic        alarm_evt = 1'b0, second_evt = 1'b0;
  logic        pin_out, pin_oe;

  int total = 0, bad = 0;
  logic [15:0] model [42];
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  bkp_domain_bank i_bkp_domain_bank (.*);

  function automatic logic [7:0] off_of(input int k);
    return (k < 10) ? 8'(4 + 4 * k) : 8'(8'h40 + 4 * (k - 10));
  endfunction

  // bench view of the map: index or -1
  function automatic int idx_of(input logic [7:0] a);
    for (int k = 0; k < 42; k++) if (off_of(k) == a) return k;
    return -1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < 42; k++) begin
      rd(off_of(k), rv);
      chk(req, rv, {16'd0, model[k]});
    end
  endtask

  task automatic finish_up;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    int hi, run, maxrun;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 42; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    bkp_rst_n = 1'b1; vdd_rst_n = 1'b1;

    rd(8'h2C, rv); chk("R4 ctrl reset", rv, 32'd0);
    rd(8'h04, rv); chk("R4 word reset", rv, 32'd0);

    // R1 directed: fill every word with its own pattern
    for (int k = 0; k < 42; k++) begin
      model[k] = 16'hA500 ^ 16'(k * 37);
      wr(off_of(k), {16'hDEAD, model[k]});
    end
    check_all("R1 map");

    // R1/R3 random traffic over the whole offset space
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      logic [31:0] d;
      int k;
      a = 8'($urandom_range(0, 255)) & 8'hFE;
      if (a == 8'h2C) a = 8'h2E;
      d = $urandom();
      k = a[1] ? -1 : idx_of(a & 8'hFC);
      if ($urandom_range(0, 1) == 1) begin
        wr(a, d);
        if (k >= 0) model[k] = d[15:0];
      end else begin
        rd(a, rv);
        chk(k >= 0 ? "R1 random read" : "R3 unmapped read", rv, k >= 0 ? {16'd0, model[k]} : 32'd0);
      end
    end
    check_all("R3 writes ignored");

    // R2 control fields
    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h2C, rv); chk("R2 ctrl fields", rv, 32'h0000_03FF);
    chk("R9 oe", {31'd0, pin_oe}, 32'd1);
    wr(8'h2E, 32'h0);
    rd(8'h2C, rv); chk("R3 upper half write ignored", rv, 32'h0000_03FF);

    // R9 clock output wins over pulse mode; tamper ignored (R7)
    tamper_en = 1'b1;
    @(negedge clk); tamper_in = 1'b1;
    hi = 0; run = 0; maxrun = 0;
    repeat (4) @(posedge clk);
    for (int c = 0; c < 128; c++) begin
      @(posedge clk); #1;
      alarm_evt = ($urandom_range(0, 3) == 0);
      second_evt = ~second_evt;
      if (pin_out) begin hi++; run++; if (run > maxrun) maxrun = run; end
      else run = 0;
    end
    chk("R9 high count", 32'(hi), 32'd64);
    chk("R9 high run", 32'(maxrun), 32'd32);
    alarm_evt = 1'b0; second_evt = 1'b0;
    tamper_in = 1'b0;
    check_all("R7 tamper ignored in clock mode");

    // R8 pulse mode, alarm then seconds
    wr(8'h2C, 32'h0000_0100);
    tamper_in = 1'b1; repeat (5) @(negedge clk); tamper_in = 1'b0;
    rd(off_of(3), rv); chk("R7 tamper ignored in pulse mode", rv, {16'd0, model[3]});
    @(negedge clk); alarm_evt = 1'b1; second_evt = 1'b1;
    @(posedge clk); #1 chk("R8 alarm pulse high", {31'd0, pin_out}, 32'd1);
    chk("R8 oe", {31'd0, pin_oe}, 32'd1);
    @(posedge clk); #1 chk("R8 alarm pulse one cycle", {31'd0, pin_out}, 32'd0);
    @(posedge clk); #1 chk("R8 held source no repeat", {31'd0, pin_out}, 32'd0);
    @(negedge clk); alarm_evt = 1'b0; second_evt = 1'b0;
    wr(8'h2C, 32'h0000_0300);
    @(negedge clk); alarm_evt = 1'b1;
    @(posedge clk); #1 chk("R8 alarm not selected", {31'd0, pin_out}, 32'd0);
    @(negedge clk); alarm_evt = 1'b0; second_evt = 1'b1;
    @(posedge clk); #1 chk("R8 seconds pulse", {31'd0, pin_out}, 32'd1);
    @(posedge clk); #1 chk("R8 seconds one cycle", {31'd0, pin_out}, 32'd0);
    @(negedge clk); second_evt = 1'b0;

    // R10 idle pin; R7 disarmed tamper
    wr(8'h2C, 32'h0000_0055);
    @(negedge clk); alarm_evt = 1'b1;
    repeat (3) @(posedge clk); #1;
    chk("R10 oe low", {31'd0, pin_oe}, 32'd0);
    chk("R10 out low", {31'd0, pin_out}, 32'd0);
    alarm_evt = 1'b0;
    tamper_en = 1'b0;
    @(negedge clk); tamper_in = 1'b1; repeat (5) @(negedge clk); tamper_in = 1'b0;
    rd(off_of(20), rv); chk("R7 tamper disabled", rv, {16'd0, model[20]});

    // R6 armed tamper, timed edge by edge
    tamper_en = 1'b1;
    repeat (3) @(negedge clk);
    tamper_in = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = off_of(0);
    repeat (2) @(posedge clk); #1 chk("R6 not yet wiped", bus_rdata, {16'd0, model[0]});
    @(posedge clk); #1 chk("R6 wiped on third edge", bus_rdata, 32'd0);
    bus_sel = 1'b0;
    for (int k = 0; k < 42; k++) model[k] = '0;
    check_all("R6 all wiped");
    rd(8'h2C, rv); chk("R6 ctrl kept", rv, 32'h0000_0055);

    // R11 held tamper wipes once
    model[7] = 16'h1234; wr(off_of(7), 32'h1234);
    repeat (6) @(negedge clk);
    rd(off_of(7), rv); chk("R11 single wipe", rv, 32'h0000_1234);
    tamper_in = 1'b0; tamper_en = 1'b0;

    // R5 supply reset
    wr(8'h2C, 32'h0000_03C5);
    @(negedge clk); vdd_rst_n = 1'b0; @(negedge clk); vdd_rst_n = 1'b1;
    rd(8'h2C, rv); chk("R5 only clock bit cleared", rv, 32'h0000_0345);
    rd(off_of(7), rv); chk("R5 data kept", rv, 32'h0000_1234);

    // R4 domain reset
    wr(8'h2C, 32'h0000_03C5);
    @(negedge clk); bkp_rst_n = 1'b0; @(negedge clk); bkp_rst_n = 1'b1;
    rd(8'h2C, rv); chk("R4 clock bit kept", rv, 32'h0000_0080);
    model[7] = '0;
    check_all("R4 data cleared");

    finish_up();
  end
endmodule